// File: doc/BRIEF.md
# Quad Low-Side Switch Protection Sequencer

This block is the digital controller behind a four-channel low-side switch. It turns four channel commands and an active-low enable into four gate-enable outputs. It watches a per-channel over-current comparator flag and two global analog flags, over-temperature and supply undervoltage. Each channel has its own timing engine. An over-current that lasts longer than a deglitch window shuts that channel off for a fixed hold-off interval, and the channel then re-arms by itself. An active-low fault flag reports any channel in hold-off and any over-temperature event.

Every asynchronous input passes through a synchronizer chain before it is used, and both outputs come from flops. The deglitch and hold-off windows are set in nanoseconds against a clock-frequency parameter, and the cycle counts are derived from them when the block is built. A chip-level power-on reset (`por_n`) brings the block to a defined idle state, so the active-high `rst_i` line never has to be pulsed at power-up.

Top module: `lsd_fault_ctrl`

## Requirements
- R1: With no fault and no reset or undervoltage, `gate_o[i]` is 1 exactly when `cmd_i[i]` is 1 and `en_n_i` is 0, and 0 otherwise. Input changes reach the outputs on the third rising clock edge after they are applied (two synchronizer flops, then one output flop).
- R2: An over-current flag that is high for fewer than DG_CYC consecutive sampled cycles causes no latch-off: the channel's gate follows its command and `fault_n_o` stays 1.
- R3: An over-current flag that is high for DG_CYC consecutive sampled cycles puts that channel into hold-off for exactly RT_CYC cycles. During hold-off its gate is 0. When hold-off ends, the channel returns to normal operation with no outside action.
- R4: `fault_n_o` is 0 while any channel is in hold-off or over-temperature is present, and 1 otherwise.
- R5: While the synchronized `rst_i` is 1, all gates are 0, commands have no effect, and every channel's timers and hold-off are cleared. After `rst_i` falls, no channel is still in hold-off.
- R6: Over-temperature forces all gates to 0 and drives `fault_n_o` to 0. When the flag falls, the gates follow their commands again with no timed wait, and the per-channel timers are left as they were.
- R7: Undervoltage forces all gates to 0 and clears every channel's state and timers, hold-off included. Normal operation resumes when the flag clears.
- R8: While `por_n` is 0 and after it rises, with idle inputs, all gates are 0 and `fault_n_o` is 1.
- R9: If a channel's over-current flag is still high when its hold-off ends, the channel enters a fresh deglitch window, and its gate follows the command during that window. It latches off again only after another DG_CYC consecutive high samples.
- R10: The four channels keep separate timers. An over-current on one channel does not change the gate of any other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Chip power-on reset, asynchronous, active low |
| cmd_i | input | NCH | Channel commands, 1 requests the switch on |
| en_n_i | input | 1 | Output enable, active low |
| rst_i | input | 1 | Logic reset, active high, clears faults |
| oc_i | input | NCH | Per-channel over-current comparator flags |
| ot_i | input | 1 | Over-temperature flag |
| uv_i | input | 1 | Supply undervoltage flag |
| gate_o | output | NCH | Registered gate enables, 1 turns the switch on |
| fault_n_o | output | 1 | Fault flag, active low |

## Verification
The bench builds the block with a 100 MHz clock, a 50 ns deglitch window and a 300 ns hold-off. That gives DG_CYC = 5 and RT_CYC = 30. With windows this short, the bench can place over-current pulses one sample below and exactly at the latch threshold, and it can hold a flag across a whole hold-off to reach the re-entry into deglitch. It can also hit a reset, an undervoltage or an over-temperature event in the middle of a hold-off, all within a few hundred cycles. The default 50 MHz build, with counts of 175 and 60000, only changes the counter width.

// File: rtl/lsd_pkg.sv
package lsd_pkg;
   typedef enum logic [1:0] {
      CH_NORMAL   = 2'd0,
      CH_DEGLITCH = 2'd1,
      CH_RETRY    = 2'd2
   } ch_state_e;

   function automatic int unsigned ns_to_cycles(input int unsigned clk_hz,
                                                input int unsigned ns);
      longint unsigned prod;
      prod = longint'(clk_hz) * longint'(ns);
      return int'(prod / 64'd1_000_000_000);
   endfunction
endpackage

// File: rtl/lsd_sync.sv
module lsd_sync #(
   parameter int unsigned W      = 1,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         por_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   initial begin
      if (STAGES < 2) $error("lsd_sync: STAGES must be at least 2");
   end

   logic [W-1:0] chain [STAGES];

   genvar s;
   generate
      for (s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge por_n) begin
               if (!por_n) chain[0] <= '0;
               else        chain[0] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge por_n) begin
               if (!por_n) chain[s] <= '0;
               else        chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   assign q_o = chain[STAGES-1];
endmodule

// File: rtl/lsd_chan_guard.sv
module lsd_chan_guard
   import lsd_pkg::*;
#(
   parameter int unsigned DG_CYC = 5,
   parameter int unsigned RT_CYC = 30,
   parameter int unsigned CW     = 6
) (
   input  logic clk,
   input  logic por_n,
   input  logic clr_i,
   input  logic oc_i,
   output logic retry_o,
   output logic dg_o
);
   localparam logic [CW-1:0] DG_LAST = CW'(DG_CYC - 1);
   localparam logic [CW-1:0] RT_LAST = CW'(RT_CYC - 1);
   localparam logic [CW-1:0] ONE     = CW'(1);

   ch_state_e     st_q;
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         st_q  <= CH_NORMAL;
         cnt_q <= '0;
      end else if (clr_i) begin
         st_q  <= CH_NORMAL;
         cnt_q <= '0;
      end else begin
         unique case (st_q)
            CH_NORMAL: begin
               if (oc_i) begin
                  st_q  <= CH_DEGLITCH;
                  cnt_q <= ONE;
               end
            end
            CH_DEGLITCH: begin
               if (!oc_i) begin
                  st_q  <= CH_NORMAL;
                  cnt_q <= '0;
               end else if (cnt_q == DG_LAST) begin
                  st_q  <= CH_RETRY;
                  cnt_q <= '0;
               end else begin
                  cnt_q <= cnt_q + ONE;
               end
            end
            CH_RETRY: begin
               if (cnt_q == RT_LAST) begin
                  if (oc_i) begin
                     st_q  <= CH_DEGLITCH;
                     cnt_q <= ONE;
                  end else begin
                     st_q  <= CH_NORMAL;
                     cnt_q <= '0;
                  end
               end else begin
                  cnt_q <= cnt_q + ONE;
               end
            end
            default: begin
               st_q  <= CH_NORMAL;
               cnt_q <= '0;
            end
         endcase
      end
   end

   assign retry_o = (st_q == CH_RETRY);
   assign dg_o    = (st_q == CH_DEGLITCH);
endmodule

// File: rtl/lsd_fault_ctrl.sv
module lsd_fault_ctrl
   import lsd_pkg::*;
#(
   parameter int unsigned NCH         = 4,
   parameter int unsigned CLK_HZ      = 50_000_000,
   parameter int unsigned DEGLITCH_NS = 3_500,
   parameter int unsigned RETRY_NS    = 1_200_000,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic           clk,
   input  logic           por_n,
   input  logic [NCH-1:0] cmd_i,
   input  logic           en_n_i,
   input  logic           rst_i,
   input  logic [NCH-1:0] oc_i,
   input  logic           ot_i,
   input  logic           uv_i,
   output logic [NCH-1:0] gate_o,
   output logic           fault_n_o
);
   localparam int unsigned DG_CYC = ns_to_cycles(CLK_HZ, DEGLITCH_NS);
   localparam int unsigned RT_CYC = ns_to_cycles(CLK_HZ, RETRY_NS);
   localparam int unsigned MAXC   = (DG_CYC > RT_CYC) ? DG_CYC : RT_CYC;
   localparam int unsigned CW     = $clog2(MAXC + 1);
   localparam int unsigned SW     = 2 * NCH + 4;

   initial begin
      if (NCH < 1)    $error("lsd_fault_ctrl: NCH must be at least 1");
      if (DG_CYC < 2) $error("lsd_fault_ctrl: deglitch window under two cycles");
      if (RT_CYC < 2) $error("lsd_fault_ctrl: hold-off window under two cycles");
   end

   logic [SW-1:0]  raw_v, syn_v;
   logic [NCH-1:0] cmd_s, oc_s;
   logic           en_s, rst_s, ot_s, uv_s;
   logic [NCH-1:0] retry_v, dg_v;
   logic           clr_all;
   logic [NCH-1:0] gate_q;
   logic           fault_n_q;

   assign raw_v = {cmd_i, oc_i, ~en_n_i, rst_i, ot_i, uv_i};

   lsd_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .por_n (por_n),
      .d_i   (raw_v),
      .q_o   (syn_v)
   );

   assign {cmd_s, oc_s, en_s, rst_s, ot_s, uv_s} = syn_v;
   assign clr_all = rst_s | uv_s;

   genvar c;
   generate
      for (c = 0; c < NCH; c++) begin : g_ch
         lsd_chan_guard #(.DG_CYC(DG_CYC), .RT_CYC(RT_CYC), .CW(CW)) u_guard (
            .clk     (clk),
            .por_n   (por_n),
            .clr_i   (clr_all),
            .oc_i    (oc_s[c]),
            .retry_o (retry_v[c]),
            .dg_o    (dg_v[c])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         gate_q    <= '0;
         fault_n_q <= 1'b1;
      end else begin
         if (clr_all || ot_s) gate_q <= '0;
         else                 gate_q <= cmd_s & {NCH{en_s}} & ~retry_v;
         fault_n_q <= ~(ot_s | ((|retry_v) & ~clr_all));
      end
   end

   assign gate_o    = gate_q;
   assign fault_n_o = fault_n_q;
endmodule

// File: rtl/lsd_fault_ctrl_chk.sv
module lsd_fault_ctrl_chk #(
   parameter int unsigned NCH = 4
) (
   input logic           clk,
   input logic           por_n,
   input logic [NCH-1:0] gate_o,
   input logic           fault_n_o,
   input logic [NCH-1:0] cmd_s,
   input logic           en_s,
   input logic           rst_s,
   input logic           uv_s,
   input logic           ot_s,
   input logic [NCH-1:0] retry_v,
   input logic [NCH-1:0] dg_v
);
   genvar i;
   generate
      for (i = 0; i < NCH; i++) begin : g_a
         assert_gate_needs_cmd_R1: assert property (@(posedge clk) disable iff (!por_n)
            gate_o[i] |-> $past(cmd_s[i] & en_s));
         assert_holdoff_after_deglitch_R3: assert property (@(posedge clk) disable iff (!por_n)
            $rose(retry_v[i]) |-> $past(dg_v[i]));
         assert_no_gate_in_holdoff_R3: assert property (@(posedge clk) disable iff (!por_n)
            $past(retry_v[i]) |-> !gate_o[i]);
      end
   endgenerate

   assert_fault_has_cause_R4: assert property (@(posedge clk) disable iff (!por_n)
      !fault_n_o |-> $past(ot_s | (|retry_v)));
   assert_reset_blocks_gates_R5: assert property (@(posedge clk) disable iff (!por_n)
      $past(rst_s) |-> (gate_o == '0));
   assert_reset_clears_holdoff_R5: assert property (@(posedge clk) disable iff (!por_n)
      $past(rst_s) |-> (retry_v == '0));
   assert_overtemp_fault_R6: assert property (@(posedge clk) disable iff (!por_n)
      $past(ot_s) |-> (!fault_n_o && gate_o == '0));
   assert_uv_clears_R7: assert property (@(posedge clk) disable iff (!por_n)
      $past(uv_s) |-> (gate_o == '0 && retry_v == '0 && dg_v == '0));
endmodule

bind lsd_fault_ctrl lsd_fault_ctrl_chk #(.NCH(NCH)) u_chk (
   .clk       (clk),
   .por_n     (por_n),
   .gate_o    (gate_o),
   .fault_n_o (fault_n_o),
   .cmd_s     (cmd_s),
   .en_s      (en_s),
   .rst_s     (rst_s),
   .uv_s      (uv_s),
   .ot_s      (ot_s),
   .retry_v   (retry_v),
   .dg_v      (dg_v)
);

// File: tb/tb_lsd_fault_ctrl.sv
`timescale 1ns/1ps
module tb_lsd_fault_ctrl;
   localparam int NCH = 4;
   localparam int DG  = 5;
   localparam int RT  = 30;

   logic           clk = 1'b0;
   logic           por_n = 1'b0;
   logic [NCH-1:0] cmd_i = '0;
   logic           en_n_i = 1'b1;
   logic           rst_i = 1'b0;
   logic [NCH-1:0] oc_i = '0;
   logic           ot_i = 1'b0;
   logic           uv_i = 1'b0;
   logic [NCH-1:0] gate_o;
   logic           fault_n_o;

   int    checks = 0;
   int    errors = 0;
   int    cyc = 0;
   string cur_req = "R8";

   always #5 clk = ~clk;

   lsd_fault_ctrl #(
      .NCH(NCH), .CLK_HZ(100_000_000), .DEGLITCH_NS(50), .RETRY_NS(300), .SYNC_STAGES(2)
   ) dut (
      .clk(clk), .por_n(por_n), .cmd_i(cmd_i), .en_n_i(en_n_i), .rst_i(rst_i),
      .oc_i(oc_i), .ot_i(ot_i), .uv_i(uv_i), .gate_o(gate_o), .fault_n_o(fault_n_o)
   );

   // behavioural reference: inputs delayed two samples, per-channel mode and timer
   int             m_mode [NCH];
   int             m_tmr  [NCH];
   logic [NCH-1:0] p1_cmd = '0, p2_cmd = '0, p1_oc = '0, p2_oc = '0;
   logic           p1_en = 0, p2_en = 0, p1_rst = 0, p2_rst = 0;
   logic           p1_ot = 0, p2_ot = 0, p1_uv = 0, p2_uv = 0;
   logic [NCH-1:0] m_gate = '0;
   logic           m_fault_n = 1'b1;

   always @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         for (int k = 0; k < NCH; k++) begin m_mode[k] = 0; m_tmr[k] = 0; end
         p1_cmd = '0; p2_cmd = '0; p1_oc = '0; p2_oc = '0;
         p1_en = 0; p2_en = 0; p1_rst = 0; p2_rst = 0;
         p1_ot = 0; p2_ot = 0; p1_uv = 0; p2_uv = 0;
         m_gate = '0; m_fault_n = 1'b1;
      end else begin
         logic any_hold;
         logic [NCH-1:0] hold;
         any_hold = 0;
         for (int k = 0; k < NCH; k++) begin
            hold[k] = (m_mode[k] == 2);
            if (hold[k]) any_hold = 1;
         end
         if (p2_rst || p2_uv || p2_ot) m_gate = '0;
         else m_gate = p2_cmd & {NCH{p2_en}} & ~hold;
         m_fault_n = !(p2_ot || (any_hold && !(p2_rst || p2_uv)));
         for (int k = 0; k < NCH; k++) begin
            if (p2_rst || p2_uv) begin
               m_mode[k] = 0; m_tmr[k] = 0;
            end else if (m_mode[k] == 0) begin
               if (p2_oc[k]) begin m_mode[k] = 1; m_tmr[k] = 1; end
            end else if (m_mode[k] == 1) begin
               if (!p2_oc[k]) begin m_mode[k] = 0; m_tmr[k] = 0; end
               else if (m_tmr[k] == DG - 1) begin m_mode[k] = 2; m_tmr[k] = 0; end
               else m_tmr[k]++;
            end else begin
               if (m_tmr[k] == RT - 1) begin
                  if (p2_oc[k]) begin m_mode[k] = 1; m_tmr[k] = 1; end
                  else begin m_mode[k] = 0; m_tmr[k] = 0; end
               end else m_tmr[k]++;
            end
         end
         p2_cmd = p1_cmd; p2_oc = p1_oc; p2_en = p1_en; p2_rst = p1_rst;
         p2_ot = p1_ot; p2_uv = p1_uv;
         p1_cmd = cmd_i; p1_oc = oc_i; p1_en = !en_n_i; p1_rst = rst_i;
         p1_ot = ot_i; p1_uv = uv_i;
      end
   end

   always @(negedge clk) begin
      cyc++;
      if (cyc >= 3) begin
         checks++;
         if (gate_o !== m_gate) begin
            errors++;
            $display("FAIL %s gate_o actual=%b expected=%b at cycle %0d", cur_req, gate_o, m_gate, cyc);
         end
         checks++;
         if (fault_n_o !== m_fault_n) begin
            errors++;
            $display("FAIL %s fault_n_o actual=%b expected=%b at cycle %0d", cur_req, fault_n_o, m_fault_n, cyc);
         end
      end
      if (cyc > 5000) begin
         errors++;
         $display("FAIL watchdog expired at cycle %0d", cyc);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic wait_cyc(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   initial begin
      // R8: power-on reset, then idle
      cur_req = "R8";
      wait_cyc(4);
      por_n = 1'b1;
      wait_cyc(6);

      // R1: command and enable patterns
      cur_req = "R1";
      cmd_i = 4'b1010; wait_cyc(5);
      en_n_i = 1'b0;   wait_cyc(5);
      cmd_i = 4'b0101; wait_cyc(1);
      cmd_i = 4'b1111; wait_cyc(5);
      en_n_i = 1'b1;   wait_cyc(5);
      en_n_i = 1'b0;   cmd_i = 4'b0011; wait_cyc(5);
      cmd_i = 4'b1111; wait_cyc(4);

      // R2: pulses below the threshold
      cur_req = "R2";
      oc_i[0] = 1'b1; wait_cyc(3); oc_i[0] = 1'b0; wait_cyc(6);
      oc_i[0] = 1'b1; wait_cyc(DG - 1); oc_i[0] = 1'b0; wait_cyc(8);

      // R3 and R10: exact threshold on channel 1, others keep running
      cur_req = "R3";
      oc_i[1] = 1'b1; wait_cyc(DG); oc_i[1] = 1'b0;
      cur_req = "R10";
      cmd_i = 4'b1101; wait_cyc(6); cmd_i = 4'b1111;
      cur_req = "R3";
      wait_cyc(RT + 10);

      // R9: flag held across a whole hold-off on channel 2
      cur_req = "R9";
      oc_i[2] = 1'b1; wait_cyc(DG + RT + 3); oc_i[2] = 1'b0; wait_cyc(RT + 10);
      cur_req = "R4";
      oc_i[0] = 1'b1; oc_i[3] = 1'b1; wait_cyc(DG + 2); oc_i[0] = 1'b0;
      wait_cyc(10); oc_i[3] = 1'b0; wait_cyc(RT + 8);

      // R5: reset during hold-off, commands toggled while held
      cur_req = "R5";
      oc_i[0] = 1'b1; wait_cyc(DG + 3); oc_i[0] = 1'b0; wait_cyc(4);
      rst_i = 1'b1; cmd_i = 4'b0110; wait_cyc(3); cmd_i = 4'b1001; wait_cyc(3);
      oc_i[2] = 1'b1; wait_cyc(DG + 2); oc_i[2] = 1'b0;
      rst_i = 1'b0; cmd_i = 4'b1111; wait_cyc(10);

      // R6: over-temperature, alone and over a running hold-off
      cur_req = "R6";
      ot_i = 1'b1; wait_cyc(8); ot_i = 1'b0; wait_cyc(6);
      oc_i[3] = 1'b1; wait_cyc(DG + 2); oc_i[3] = 1'b0; wait_cyc(3);
      ot_i = 1'b1; wait_cyc(6); ot_i = 1'b0; wait_cyc(RT + 6);

      // R7: undervoltage clears a hold-off and a partial deglitch
      cur_req = "R7";
      oc_i[1] = 1'b1; wait_cyc(DG + 3); oc_i[1] = 1'b0;
      oc_i[2] = 1'b1; wait_cyc(2);
      uv_i = 1'b1; wait_cyc(5); uv_i = 1'b0; wait_cyc(2);
      wait_cyc(DG - 2); oc_i[2] = 1'b0; wait_cyc(12);

      // R1: enable released at end
      cur_req = "R1";
      en_n_i = 1'b1; wait_cyc(6);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule